// File: doc/BRIEF.md
# Committed Jump Target Recorder

This block keeps a record of the destinations reached by register-indirect jumps as they retire. The commit stage presents one optional address per superscalar lane every cycle. A lane marks its slot valid only when the instruction it retires is an indirect jump, whether a plain jump-register or a capability jump-and-link-register. In that case the slot carries the jump's predicted next address. Each lane owns a small fully associative set. The set fills once, in arrival order, and never evicts.

Elsewhere in the pipeline, a stage that holds a predicted address can ask whether that address is a known jump destination. It drives the address on a single lookup port. The answer is one bit, formed combinationally from the registered contents of every lane's set. Each stored entry uses the same address as its match key and as its payload, so only the address is kept.

Top module: `jtgt_recorder`

## Requirements
- R1: A lane stores its address only when its bit in `ins_valid` is 1. An address offered with the valid bit at 0 leaves every set unchanged and is not found by a later lookup.
- R2: `query_hit` is 1 exactly when `query_addr` equals a stored address in at least one lane's set. It is the OR of the per-lane matches.
- R3: Each lane's set holds at most DEPTH addresses (16 by default). Once a lane holds DEPTH entries, new addresses offered to it are dropped and the entries already stored stay in place.
- R4: If an address is offered to a lane that already holds it, no new entry is used in that lane.
- R5: While `rst` is 1 at a rising clock edge, every entry in every lane is cleared, so that afterwards no lookup hits.
- R6: An address stored at a rising edge can be found by lookups from the following cycle on. A lookup in the same cycle as the insert does not see it.
- R7: The lanes fill independently. One lane being full, or receiving a duplicate, has no effect on inserts to another lane.
- R8: The address width (ADDR_W, 64 by default), the lane count (LANES, 2 by default) and the per-lane depth (DEPTH, 16 by default) are parameters. Lane k's address occupies bits `[k*ADDR_W +: ADDR_W]` of `ins_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; clears all entries |
| ins_valid | input | LANES | Per-lane insert strobe; bit k marks lane k's address as a valid jump target |
| ins_addr | input | LANES*ADDR_W | Per-lane target addresses, with lane k at bits [k*ADDR_W +: ADDR_W] |
| query_addr | input | ADDR_W | Address to look up |
| query_hit | output | 1 | 1 when query_addr is stored in any lane |

## Verification
The bench builds the block with ADDR_W=20, LANES=3 and DEPTH=16. The third lane checks that the OR-merge and the flattened lane slicing work beyond the default pair of lanes. The narrow addresses make it possible to draw random traffic from a pool of forty addresses. With that pool, duplicates are frequent and every lane fills to DEPTH during the random run, so the drop-when-full path is hit repeatedly. Directed steps add a duplicate followed by a fill to the last slot, an overflow insert, a lookup in the same cycle as the insert, and a reset in the middle of the run.

// File: rtl/jtgt_pkg.sv
package jtgt_pkg;

    localparam int DEF_ADDR_W = 64;
    localparam int DEF_LANES  = 2;
    localparam int DEF_DEPTH  = 16;

    // Width of a counter that must reach the value depth itself.
    function automatic int fill_width(input int depth);
        return $clog2(depth + 1);
    endfunction

    // Per-entry state of one associative slot.
    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_USED = 1'b1
    } slot_state_e;

endpackage

// File: rtl/jtgt_lane_set.sv
module jtgt_lane_set
    import jtgt_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DEPTH  = DEF_DEPTH,
    localparam int CW    = fill_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_vld,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [ADDR_W-1:0] qry_addr,
    output logic              qry_hit,
    output logic [CW-1:0]     fill_cnt
);

    slot_state_e             state_q [DEPTH];
    logic [ADDR_W-1:0]       key_q   [DEPTH];
    logic [DEPTH-1:0]        qry_match;
    logic [DEPTH-1:0]        dup_match;
    logic [DEPTH-1:0]        wr_en;
    logic [CW-1:0]           fill_q;
    logic                    has_room;
    logic                    accept;

    assign has_room = (fill_q < CW'(DEPTH));
    assign accept   = ins_vld && has_room && (dup_match == '0);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign qry_match[i] = (state_q[i] == SLOT_USED) && (key_q[i] == qry_addr);
        assign dup_match[i] = (state_q[i] == SLOT_USED) && (key_q[i] == ins_addr);
        assign wr_en[i]     = accept && (fill_q == CW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                state_q[i] <= SLOT_FREE;
            end else if (wr_en[i]) begin
                state_q[i] <= SLOT_USED;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en[i]) begin
                key_q[i] <= ins_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q <= '0;
        end else if (accept) begin
            fill_q <= fill_q + CW'(1);
        end
    end

    assign qry_hit  = |qry_match;
    assign fill_cnt = fill_q;

endmodule

// File: rtl/jtgt_hit_merge.sv
module jtgt_hit_merge
    import jtgt_pkg::*;
#(
    parameter int LANES = DEF_LANES
) (
    input  logic [LANES-1:0] lane_hit,
    output logic             any_hit
);

    logic [LANES:0] chain;

    assign chain[0] = 1'b0;
    for (genvar k = 0; k < LANES; k++) begin : g_or
        assign chain[k+1] = chain[k] | lane_hit[k];
    end

    assign any_hit = chain[LANES];

endmodule

// File: rtl/jtgt_recorder.sv
module jtgt_recorder
    import jtgt_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int LANES  = DEF_LANES,
    parameter int DEPTH  = DEF_DEPTH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES-1:0]        ins_valid,
    input  logic [LANES*ADDR_W-1:0] ins_addr,
    input  logic [ADDR_W-1:0]       query_addr,
    output logic                    query_hit
);

    localparam int CW = fill_width(DEPTH);

    logic [LANES-1:0]    lane_hit;
    logic [LANES*CW-1:0] lane_fill;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        jtgt_lane_set #(
            .ADDR_W (ADDR_W),
            .DEPTH  (DEPTH)
        ) u_set (
            .clk      (clk),
            .rst      (rst),
            .ins_vld  (ins_valid[k]),
            .ins_addr (ins_addr[k*ADDR_W +: ADDR_W]),
            .qry_addr (query_addr),
            .qry_hit  (lane_hit[k]),
            .fill_cnt (lane_fill[k*CW +: CW])
        );
    end

    jtgt_hit_merge #(
        .LANES (LANES)
    ) u_merge (
        .lane_hit (lane_hit),
        .any_hit  (query_hit)
    );

endmodule

// File: rtl/jtgt_recorder_chk.sv
module jtgt_recorder_chk
    import jtgt_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int LANES  = DEF_LANES,
    parameter int DEPTH  = DEF_DEPTH,
    localparam int CW    = fill_width(DEPTH)
) (
    input logic                    clk,
    input logic                    rst,
    input logic [LANES-1:0]        ins_valid,
    input logic [LANES*ADDR_W-1:0] ins_addr,
    input logic [ADDR_W-1:0]       query_addr,
    input logic                    query_hit,
    input logic [LANES*CW-1:0]     lane_fill
);

    // R5: the cycle after reset sees every lane empty
    a_r5_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (lane_fill == '0));

    // R2: with all lanes empty nothing can hit
    a_r2_empty_no_hit: assert property (@(posedge clk) disable iff (rst)
        (lane_fill == '0) |-> !query_hit);

    for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
        // R3: occupancy never exceeds the depth
        a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
            lane_fill[k*CW +: CW] <= CW'(DEPTH));

        // R1 and R4: occupancy grows by one at most, and only after a valid offer
        a_r1_growth_needs_valid: assert property (@(posedge clk) disable iff (rst)
            (lane_fill[k*CW +: CW] != $past(lane_fill[k*CW +: CW])) |->
                ($past(ins_valid[k]) &&
                 (lane_fill[k*CW +: CW] == $past(lane_fill[k*CW +: CW]) + CW'(1))));

        // R6: an address offered to a lane with room is found on the next cycle
        a_r6_visible_next: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(ins_valid[k]) &&
             ($past(lane_fill[k*CW +: CW]) < CW'(DEPTH)) &&
             (query_addr == $past(ins_addr[k*ADDR_W +: ADDR_W]))) |-> query_hit);
    end

endmodule

bind jtgt_recorder jtgt_recorder_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .DEPTH  (DEPTH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ins_valid  (ins_valid),
    .ins_addr   (ins_addr),
    .query_addr (query_addr),
    .query_hit  (query_hit),
    .lane_fill  (lane_fill)
);

// File: tb/test_jtgt_recorder.sv
module test_jtgt_recorder;

    localparam int AW    = 20;
    localparam int NL    = 3;
    localparam int DEPTH = 16;
    localparam int POOL  = 40;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [NL-1:0]        ins_valid;
    logic [NL*AW-1:0]     ins_addr;
    logic [AW-1:0]        query_addr;
    logic                 query_hit;

    logic [AW-1:0]        drv_a [NL];

    int checks = 0;
    int errors = 0;

    // bench model of the stored contents
    logic [AW-1:0]        m_mem [NL][DEPTH];
    int                   m_cnt [NL];

    always #10 clk = ~clk;

    always_comb begin
        for (int k = 0; k < NL; k++) ins_addr[k*AW +: AW] = drv_a[k];
    end

    jtgt_recorder #(.ADDR_W(AW), .LANES(NL), .DEPTH(DEPTH)) i_jtgt_recorder (
        .clk        (clk),
        .rst        (rst),
        .ins_valid  (ins_valid),
        .ins_addr   (ins_addr),
        .query_addr (query_addr),
        .query_hit  (query_hit)
    );

    function automatic logic m_lane_has(int l, logic [AW-1:0] a);
        for (int j = 0; j < m_cnt[l]; j++) if (m_mem[l][j] == a) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic m_hit(logic [AW-1:0] a);
        logic r = 1'b0;
        for (int l = 0; l < NL; l++) r = r | m_lane_has(l, a);
        return r;
    endfunction

    function automatic logic [AW-1:0] pool_addr(int i);
        return AW'(20'h0A000 + i * 52);
    endfunction

    task automatic m_clear();
        for (int l = 0; l < NL; l++) m_cnt[l] = 0;
    endtask

    task automatic m_insert();
        for (int l = 0; l < NL; l++) begin
            if (ins_valid[l] && !m_lane_has(l, drv_a[l]) && m_cnt[l] < DEPTH) begin
                m_mem[l][m_cnt[l]] = drv_a[l];
                m_cnt[l]++;
            end
        end
    endtask

    task automatic check(logic act, logic exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: query %h actual %b expected %b", req, query_addr, act, exp);
        end
    endtask

    // combinational probe with no inserts, no clock edge
    task automatic probe(logic [AW-1:0] a, logic exp, string req);
        ins_valid  = '0;
        query_addr = a;
        #1;
        check(query_hit, exp, req);
        #1;
    endtask

    // one cycle: inputs already set; checks lookup against model before the edge
    task automatic tick(string req);
        #1;
        check(query_hit, m_hit(query_addr), req);
        @(posedge clk);
        m_insert();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        ins_valid  = '0;
        query_addr = '0;
        for (int k = 0; k < NL; k++) drv_a[k] = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle_inputs();
        repeat (2) @(posedge clk);
        m_clear();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] a1, c1, d1;
        void'($urandom(32'd1234));
        a1 = 20'h12340;
        c1 = 20'h77770;
        d1 = 20'h5A5A0;
        idle_inputs();
        m_clear();
        @(negedge clk);
        do_reset();

        // R5: nothing stored after reset
        probe(a1, 1'b0, "R5");
        probe('0, 1'b0, "R5");

        // R1: invalid slot is not stored
        drv_a[0] = a1; ins_valid = 3'b000; query_addr = a1;
        tick("R1");
        probe(a1, 1'b0, "R1");

        // R6: same-cycle lookup misses, next cycle hits
        drv_a[0] = a1; ins_valid = 3'b001; query_addr = a1;
        #1; check(query_hit, 1'b0, "R6"); #1;
        tick("R6");
        probe(a1, 1'b1, "R6");

        // R4: duplicate then 15 new addresses; the last must still fit
        drv_a[0] = a1; ins_valid = 3'b001; query_addr = a1;
        tick("R4");
        for (int i = 0; i < DEPTH - 1; i++) begin
            drv_a[0] = AW'(20'h30000 + i * 16); ins_valid = 3'b001; query_addr = a1;
            tick("R4");
        end
        probe(AW'(20'h30000 + (DEPTH - 2) * 16), 1'b1, "R4");

        // R3: lane 0 is full; a new address is dropped, old ones remain
        drv_a[0] = c1; ins_valid = 3'b001; query_addr = a1;
        tick("R3");
        probe(c1, 1'b0, "R3");
        probe(a1, 1'b1, "R3");
        probe(AW'(20'h30000), 1'b1, "R3");

        // R7: other lanes still accept while lane 0 is full
        drv_a[0] = 20'h44440; drv_a[1] = c1; drv_a[2] = d1;
        ins_valid = 3'b111; query_addr = c1;
        tick("R7");
        probe(c1, 1'b1, "R7");
        probe(20'h44440, 1'b0, "R7");

        // R2 and R8: hits from each lane through the merged output
        probe(d1, 1'b1, "R2");
        probe(AW'(20'h30000 + 3 * 16), 1'b1, "R2");
        probe(20'h00001, 1'b0, "R2");
        probe(d1 ^ 20'h80000, 1'b0, "R8");

        // R5: reset in the middle of activity clears every lane
        do_reset();
        probe(a1, 1'b0, "R5");
        probe(c1, 1'b0, "R5");
        probe(d1, 1'b0, "R5");

        // random traffic from a small pool (R1, R2, R3, R4, R6, R7)
        for (int n = 0; n < 600; n++) begin
            for (int k = 0; k < NL; k++) begin
                ins_valid[k] = ($urandom % 2) == 0;
                drv_a[k]     = pool_addr(int'($urandom % POOL));
            end
            if (($urandom % 10) < 7) query_addr = pool_addr(int'($urandom % POOL));
            else                     query_addr = AW'($urandom);
            tick("R2");
        end
        for (int i = 0; i < POOL; i++) probe(pool_addr(i), m_hit(pool_addr(i)), "R3");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule